// File: doc/BRIEF.md
# Pointer-in-Memory Direct Transfer Controller

This block moves single words between device channels and a shared memory. It does this with no processor instructions. Channels keep no buffer registers inside the block. Each channel owns two consecutive words in low memory: a current address word, then a last address word. When a device asks for service, the controller works through a fixed sequence on its one memory port: read the current word, read the last word, move one data word, then write the advanced current word back.

The top bit of the current word gives the direction. When it is set, the word offered by the device goes to memory. When it is clear, a word is read from memory and handed to the device. The controller keeps that bit when it writes the advanced address back. A channel whose buffer is used up signals completion and then ignores its requests. It stays that way until the processor writes a new current word for that channel, which the controller sees on a write-snoop input.

Two device types can be given the same channel number and so share one pointer pair. Only one of them is fitted in any legal configuration, so the controller needs no extra logic for this.

Top module: `ptr_dma_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req`, `chan_ack` and `chan_done` are all zero, and every channel accepts requests.
- R2: Serving channel n (bit n of the request vector) starts with a read of address BASE+2n (current word) and then a read of BASE+2n+1 (last word). With the default BASE of 16, channel n's current word is at 16+2n.
- R3: The data access uses bits AW-2:0 of the current word as its address. If bit AW-1 is 1, the word on channel n's slice of `chan_in_data` is written there. If bit AW-1 is 0, that address is read, and the word appears on `chan_out_data` in the cycle `chan_ack` pulses.
- R4: The last access of a service writes to BASE+2n the incremented address part, with bit AW-1 of the current word unchanged.
- R5: If the incremented address part is greater than the last word's address part (bit AW-1 of the last word is ignored), `chan_done[n]` pulses together with `chan_ack[n]`. After that, channel n's requests start no service.
- R6: A snooped processor write to address BASE+2n makes a stopped channel n accept requests again.
- R7: When several armed channels request in the same idle cycle, the lowest-numbered one is served first.
- R8: `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_req` is high and `mem_gnt` is low. An access completes in the cycle `mem_gnt` is high. Read data is taken from `mem_rdata` one cycle later.
- R9: `chan_ack` is one-hot and pulses only in the cycle the write-back is granted. Each pulse accounts for exactly one data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | NCH | Per-channel service request, held until acknowledged |
| chan_in_data | input | NCH*AW | Per-channel word offered to memory (slice n is channel n) |
| chan_ack | output | NCH | One-cycle pulse: one word moved for that channel |
| chan_done | output | NCH | One-cycle pulse: that channel's buffer is exhausted |
| chan_out_data | output | AW | Word read from memory, valid with an output-channel acknowledge |
| cpu_wr_valid | input | 1 | Processor memory write seen this cycle |
| cpu_wr_addr | input | AW | Address of the snooped processor write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | AW | Memory write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | AW | Read data, valid the cycle after a read grant |

## Verification
A wrong internal state here surfaces on the memory port within one access. A channel index latched wrongly shows up at once as a wrong pointer address. A captured word that is off shows up as a wrong data address or a wrong write-back value a few cycles later. A mistake in the stop flags is quieter: the service either fails to start or starts against a stopped channel. It is seen only in the idle cycle after the request, which is why the memory-port outputs are compared against a model on every clock. Errors in the completion compare are seen only when a buffer reaches its last word. So buffers are set up to end after one, two and four words, and one starts out already past its end.

// File: rtl/ptr_dma_ctrl.sv
module ptr_dma_ctrl #(
  parameter int NCH  = 16,
  parameter int AW   = 16,
  parameter int BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_req,
  input  logic [NCH*AW-1:0] chan_in_data,
  output logic [NCH-1:0]    chan_ack,
  output logic [NCH-1:0]    chan_done,
  output logic [AW-1:0]     chan_out_data,
  input  logic              cpu_wr_valid,
  input  logic [AW-1:0]     cpu_wr_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [AW-1:0]     mem_rdata
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CUR, S_CAP_CUR, S_RD_LAST, S_CAP_LAST, S_XFER, S_CAP_DATA, S_WBACK
  } state_t;

  state_t         st;
  logic [CW-1:0]  ch;
  logic [AW-1:0]  cur_w, last_w, data_r;
  logic [NCH-1:0] stopped;

  logic [NCH-1:0] elig;
  logic [CW-1:0]  pick;
  logic           any;
  logic [AW-1:0]  ptr_addr, next_a, last_a, wb_word;
  logic           dir_in, exhausted, wb_fire;

  assign elig = chan_req & ~stopped;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick = CW'(i);
        any  = 1'b1;
      end
    end
  end

  assign ptr_addr  = AW'(BASE) + (AW'(ch) << 1);
  assign dir_in    = cur_w[AW-1];
  assign next_a    = {1'b0, cur_w[AW-2:0]} + AW'(1);
  assign last_a    = {1'b0, last_w[AW-2:0]};
  assign wb_word   = {dir_in, next_a[AW-2:0]};
  assign exhausted = next_a > last_a;
  assign wb_fire   = (st == S_WBACK) && mem_gnt;

  assign mem_req = (st == S_RD_CUR) || (st == S_RD_LAST) || (st == S_XFER) || (st == S_WBACK);
  assign mem_we  = (st == S_WBACK) || ((st == S_XFER) && dir_in);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RD_CUR:  mem_addr = ptr_addr;
      S_RD_LAST: mem_addr = ptr_addr + AW'(1);
      S_XFER: begin
        mem_addr  = {1'b0, cur_w[AW-2:0]};
        mem_wdata = dir_in ? data_r : '0;
      end
      S_WBACK: begin
        mem_addr  = ptr_addr;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  assign chan_ack      = wb_fire ? (NCH'(1) << ch) : '0;
  assign chan_done     = (wb_fire && exhausted) ? (NCH'(1) << ch) : '0;
  assign chan_out_data = data_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch     <= '0;
      cur_w  <= '0;
      last_w <= '0;
      data_r <= '0;
    end else begin
      case (st)
        S_IDLE: if (any) begin
          ch <= pick;
          st <= S_RD_CUR;
        end
        S_RD_CUR:  if (mem_gnt) st <= S_CAP_CUR;
        S_CAP_CUR: begin
          cur_w <= mem_rdata;
          st    <= S_RD_LAST;
        end
        S_RD_LAST: if (mem_gnt) st <= S_CAP_LAST;
        S_CAP_LAST: begin
          last_w <= mem_rdata;
          data_r <= chan_in_data[ch*AW +: AW];
          st     <= S_XFER;
        end
        S_XFER: if (mem_gnt) st <= dir_in ? S_WBACK : S_CAP_DATA;
        S_CAP_DATA: begin
          data_r <= mem_rdata;
          st     <= S_WBACK;
        end
        S_WBACK: if (mem_gnt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_arm
    localparam logic [AW-1:0] CUR_ADDR = AW'(BASE + 2 * n);
    always_ff @(posedge clk) begin
      if (!rst_n)
        stopped[n] <= 1'b0;
      else if (wb_fire && exhausted && (ch == CW'(n)))
        stopped[n] <= 1'b1;
      else if (cpu_wr_valid && (cpu_wr_addr == CUR_ADDR))
        stopped[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/ptr_dma_ctrl_chk.sv
module ptr_dma_ctrl_chk #(
  parameter int NCH  = 16,
  parameter int AW   = 16,
  parameter int BASE = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_ack,
  input logic [NCH-1:0] chan_done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [AW-1:0]  mem_wdata,
  input logic           mem_gnt
);
  a_r8_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));

  a_r9_ack_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack) |-> mem_req && mem_we && mem_gnt);

  a_r4_writeback_targets_own_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack) |-> (mem_addr >= AW'(BASE)) && (mem_addr < AW'(BASE + 2 * NCH)) && !mem_addr[0]
                    && (chan_ack == (NCH'(1) << ((mem_addr - AW'(BASE)) >> 1))));

  a_r5_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done & ~chan_ack) == '0);

  a_r9_idle_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack) |=> !mem_req);
endmodule

bind ptr_dma_ctrl ptr_dma_ctrl_chk #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_chk (.*);

// File: tb/tb_ptr_dma_ctrl.sv
module tb_ptr_dma_ctrl;
  localparam int NCH = 16, AW = 16, BASE = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    chan_req = '0;
  logic [NCH*AW-1:0] chan_in_data = '0;
  logic [NCH-1:0]    chan_ack, chan_done;
  logic [AW-1:0]     chan_out_data;
  logic              cpu_wr_valid = 1'b0;
  logic [AW-1:0]     cpu_wr_addr = '0, cpu_wr_data = '0;
  logic              mem_req, mem_we, mem_gnt = 1'b0;
  logic [AW-1:0]     mem_addr, mem_wdata, mem_rdata = '0;

  ptr_dma_ctrl #(.NCH(NCH), .AW(AW), .BASE(BASE)) dut (.*);

  always #10 clk = ~clk;

  logic [AW-1:0] mem [0:255];
  logic [AW-1:0] ref_mem [0:255];

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
    if (cpu_wr_valid) mem[cpu_wr_addr[7:0]] <= cpu_wr_data;
  end

  int ntests = 0, nfail = 0;
  int pend [NCH];
  int kcnt [NCH];
  int ndone [NCH];
  int order [$];

  int phase = 0, mch = 0;
  logic [AW-1:0] mcur, mlast, mdata;
  logic [NCH-1:0] mstop = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] in_val(int n, int k);
    return {n[3:0], 4'h5, k[7:0]};
  endfunction

  function automatic logic [AW-1:0] paddr(int n);
    return AW'(BASE + 2 * n);
  endfunction

  task automatic drive_req();
    for (int n = 0; n < NCH; n++) begin
      chan_req[n] = pend[n] > 0;
      chan_in_data[n*AW +: AW] = in_val(n, kcnt[n]);
    end
  endtask

  task automatic cycle(bit snoop, logic [AW-1:0] sa, logic [AW-1:0] sd);
    logic exp_req, exp_we;
    logic [AW-1:0] exp_addr, exp_wd, nexta;
    logic [NCH-1:0] exp_ack, exp_done;
    string tag;
    int np;
    @(negedge clk);
    mem_gnt      = ($urandom % 4) != 0;
    cpu_wr_valid = snoop;
    cpu_wr_addr  = sa;
    cpu_wr_data  = sd;
    drive_req();
    #1;
    exp_req = 0; exp_we = 0; exp_addr = '0; exp_wd = '0;
    exp_ack = '0; exp_done = '0; np = phase; tag = "R7";
    case (phase)
      0: begin
        tag = "R5";
        for (int n = NCH - 1; n >= 0; n--)
          if (chan_req[n] && !mstop[n]) begin mch = n; np = 1; end
      end
      1: begin tag = "R2"; exp_req = 1; exp_addr = paddr(mch); if (mem_gnt) np = 2; end
      2: begin tag = "R8"; mcur = ref_mem[paddr(mch)]; np = 3; end
      3: begin tag = "R2"; exp_req = 1; exp_addr = paddr(mch) + 1; if (mem_gnt) np = 4; end
      4: begin
        tag = "R8"; mlast = ref_mem[paddr(mch) + 1];
        mdata = in_val(mch, kcnt[mch]); np = 5;
      end
      5: begin
        tag = "R3"; exp_req = 1; exp_we = mcur[AW-1];
        exp_addr = {1'b0, mcur[AW-2:0]};
        exp_wd = exp_we ? mdata : '0;
        if (mem_gnt) begin
          if (exp_we) begin ref_mem[exp_addr[7:0]] = mdata; np = 7; end
          else np = 6;
        end
      end
      6: begin tag = "R8"; mdata = ref_mem[mcur[7:0]]; np = 7; end
      default: begin
        tag = "R4"; exp_req = 1; exp_we = 1; exp_addr = paddr(mch);
        nexta = {1'b0, mcur[AW-2:0]} + 1;
        exp_wd = {mcur[AW-1], nexta[AW-2:0]};
        if (mem_gnt) begin
          exp_ack[mch] = 1'b1;
          ref_mem[paddr(mch)] = exp_wd;
          if (!mcur[AW-1]) chk("R3 out data", chan_out_data, mdata);
          np = 0;
        end
      end
    endcase
    chk({tag, " mem_req"}, mem_req, exp_req);
    if (exp_req) begin
      chk({tag, " mem_we"}, mem_we, exp_we);
      chk({tag, " mem_addr"}, mem_addr, exp_addr);
      if (exp_we) chk({tag, " mem_wdata"}, mem_wdata, exp_wd);
    end
    if (snoop) begin
      ref_mem[sa[7:0]] = sd;
      for (int n = 0; n < NCH; n++) if (sa == paddr(n)) mstop[n] = 1'b0;
    end
    if (|exp_ack) begin
      if (nexta > {1'b0, mlast[AW-2:0]}) begin
        exp_done[mch] = 1'b1;
        mstop[mch] = 1'b1;
      end
    end
    chk("R9 chan_ack", chan_ack, exp_ack);
    chk("R5 chan_done", chan_done, exp_done);
    for (int n = 0; n < NCH; n++) begin
      if (chan_ack[n]) begin
        order.push_back(n);
        pend[n]--;
        kcnt[n]++;
      end
      if (chan_done[n]) ndone[n]++;
    end
    drive_req();
    phase = np;
  endtask

  task automatic run_quiet(int maxc);
    int quiet = 0;
    for (int c = 0; c < maxc && quiet < 20; c++) begin
      cycle(0, '0, '0);
      if (phase == 0 && ((chan_req & ~mstop) == '0)) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [AW-1:0] d);
    cycle(1, a, d);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = AW'(16'hC000 + a);
      ref_mem[a] = AW'(16'hC000 + a);
    end
    for (int n = 0; n < NCH; n++) begin pend[n] = 0; kcnt[n] = 0; ndone[n] = 0; end
    mem[paddr(0)] = 16'h8040;  mem[paddr(0) + 1] = 16'h0043;
    mem[paddr(3)] = 16'h0060;  mem[paddr(3) + 1] = 16'h0061;
    mem[paddr(7)] = 16'h0070;  mem[paddr(7) + 1] = 16'h006F;
    mem[paddr(15)] = 16'h8080; mem[paddr(15) + 1] = 16'h8080;
    for (int a = 0; a < 256; a++) ref_mem[a] = mem[a];

    repeat (3) @(negedge clk);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 chan_ack", chan_ack, 0);
    chk("R1 chan_done", chan_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 mem_req after reset", mem_req, 0);

    pend[0] = 6; pend[3] = 3; pend[7] = 1; pend[15] = 2;
    run_quiet(3000);

    chk("R7 ack count", order.size(), 8);
    if (order.size() == 8) begin
      int expo [8] = '{0, 0, 0, 0, 3, 3, 7, 15};
      for (int i = 0; i < 8; i++) chk("R7 service order", order[i], expo[i]);
    end
    chk("R5 ch0 done count", ndone[0], 1);
    chk("R5 ch3 done count", ndone[3], 1);
    chk("R5 ch7 done count", ndone[7], 1);
    chk("R5 ch15 done count", ndone[15], 1);
    chk("R5 ch0 left pending", pend[0], 2);
    chk("R5 ch3 left pending", pend[3], 1);
    for (int k = 0; k < 4; k++) chk("R3 ch0 stored word", mem[8'h40 + k], in_val(0, k));
    chk("R4 ch0 write-back", mem[paddr(0)], 16'h8044);
    chk("R4 ch3 write-back", mem[paddr(3)], 16'h0062);
    chk("R4 ch7 write-back", mem[paddr(7)], 16'h0071);
    chk("R3 ch15 stored word", mem[8'h80], in_val(15, 0));
    chk("R4 ch15 write-back", mem[paddr(15)], 16'h8081);

    cpu_write(paddr(15) + 1, 16'h8091);
    chk("R6 last-word write keeps ch15 stopped", mem_req, 0);
    cpu_write(paddr(15), 16'h8090);
    run_quiet(1000);
    chk("R6 ch15 rearmed and served", pend[15], 0);
    chk("R6 ch15 no new done", ndone[15], 1);
    chk("R3 ch15 rearmed word", mem[8'h90], in_val(15, 1));
    chk("R4 ch15 rearmed write-back", mem[paddr(15)], 16'h8091);
    chk("R5 ch0 still stopped", pend[0], 2);

    for (int a = 0; a < 256; a++)
      if (mem[a] !== ref_mem[a]) chk("R4 memory image", mem[a], ref_mem[a]);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule